// File: doc/BRIEF.md
# Variable-Latency Cache-Line Host Responder

This block stands in for a host memory port during simulation of an accelerator. It serves two independent request channels: a read channel and a write channel. Every request names a cache line, counted in whole lines, and carries a tag. The response comes back later with the same tag. Read responses also carry the line contents. Lines are 512 bits wide by default. The backing store is a small line memory inside the block.

Each accepted request waits for its own countdown. The start value of that countdown is a base latency plus the low part of a free-running cycle counter. Requests accepted on successive cycles can therefore mature in a different order than they arrived. Each channel keeps a pending table in arrival order. On every cycle, each channel retires the oldest entry whose countdown is exhausted.

The request side is a valid/ready stream with an inverted ready: the block takes a request on a rising edge where the channel's valid is high and its almost-full flag is low. A request offered while almost-full is high is dropped, not held. The requester must keep offering it until a cycle where the flag is low. The response side has no back-pressure. A response valid lasts one cycle per retired request and cannot be stalled.

Top module: `hostline_responder`

## Requirements
- R1: A request accepted on a rising edge while the cycle counter reads p gets a latency of L = LAT_BASE + (p mod LAT_PHASES), which is 8 + (p mod 8) by default. The counter is 0 in the first cycle after reset and advances by one on every edge. When no older entry of the same channel is ready, the response valid is high in the cycle that follows the L-th rising edge after acceptance.
- R2: A channel's almost-full output is high exactly when that channel holds AF_LEVEL or more outstanding entries (default 16). The count is updated on every edge.
- R3: A request is taken only when its valid is high and that channel's almost-full is low. A request offered while almost-full is high produces no response and does not touch the line memory.
- R4: On each edge, every pending countdown above zero decreases by one. Of the entries at zero, only the oldest (lowest table position) retires. The others keep waiting, so a younger request with a shorter latency may answer before an older one.
- R5: Every response carries the tag its request was accepted with.
- R6: A read's data is the line content at the edge of acceptance. A write accepted on that same edge, or later, to the same line does not change the returned data.
- R7: A write updates the line memory on its accepting edge. A read accepted on any later edge sees the new data, even if the write's acknowledgement has not yet come back.
- R8: The two channels are independent. A full read channel does not block or delay write acceptance or write acknowledgements, and the reverse holds too.
- R9: Reset empties both pending tables, zeroes the cycle counter and drives both response valids and both almost-full flags low. No request pending before a reset is ever answered after it.
- R10: Each accepted request yields exactly one response valid cycle on its channel. Each channel issues at most one response per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_req_valid | input | 1 | Read request offered |
| rd_req_addr | input | ADDR_W | Line index to read |
| rd_req_tag | input | TAG_W | Tag echoed on the read response |
| rd_almost_full | output | 1 | Read channel refuses requests (inverse ready) |
| wr_req_valid | input | 1 | Write request offered |
| wr_req_addr | input | ADDR_W | Line index to write |
| wr_req_tag | input | TAG_W | Tag echoed on the write acknowledgement |
| wr_req_data | input | LINE_W | Line contents to store |
| wr_almost_full | output | 1 | Write channel refuses requests (inverse ready) |
| rd_rsp_valid | output | 1 | One-cycle read response strobe |
| rd_rsp_tag | output | TAG_W | Tag of the retiring read |
| rd_rsp_data | output | LINE_W | Line captured when the read was accepted |
| wr_rsp_valid | output | 1 | One-cycle write acknowledgement strobe |
| wr_rsp_tag | output | TAG_W | Tag of the retiring write |

## Verification
Every output of this block is registered. A response to a request accepted on edge k can first appear after edge k+L. It appears later if an older entry of the same channel is ready in the same cycle. The almost-full flags show the table occupancy left by the most recent edge. The bench keeps its own pending model. That model advances on each rising edge, using the stimulus that was held stable since the previous falling edge, and predicts what every output should show after that edge. A monitor then compares each output with the prediction at the next falling edge. The result is that every response valid, tag, data word and almost-full level is checked in the exact cycle the requirements put it in.

// File: rtl/hlr_pkg.sv
package hlr_pkg;

  // Channel flavour: selects whether a pending table carries line data.
  typedef enum logic {
    HLR_CH_READ  = 1'b0,
    HLR_CH_WRITE = 1'b1
  } hlr_chan_e;

  // Latency granted to a request accepted while the counter shows phase.
  function automatic int unsigned hlr_latency(input int unsigned base,
                                              input int unsigned phase);
    return base + phase;
  endfunction

endpackage

// File: rtl/hlr_phase_counter.sv
module hlr_phase_counter #(
  parameter int unsigned PHASES = 8,
  localparam int unsigned PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] phase
);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (phase == PW'(PHASES - 1)) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/hlr_line_mem.sv
module hlr_line_mem #(
  parameter int unsigned LINE_W = 512,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned NLINES = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LINE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [LINE_W-1:0] rdata
);

  logic [LINE_W-1:0] lines [NLINES];

  // Read is combinational: a read accepted on the same edge as a write
  // to the same line captures the content from before that write.
  assign rdata = lines[raddr];

  always_ff @(posedge clk) begin
    if (we) begin
      lines[waddr] <= wdata;
    end
  end

endmodule

// File: rtl/hlr_pending_table.sv
module hlr_pending_table
  import hlr_pkg::*;
#(
  parameter int unsigned PAY_W  = 16,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned BASE   = 8,
  parameter int unsigned PHASES = 8,
  localparam int unsigned PW    = (PHASES > 1) ? $clog2(PHASES) : 1,
  localparam int unsigned CD_W  = $clog2(BASE + PHASES),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_valid,
  input  logic [PAY_W-1:0] push_payload,
  input  logic [PW-1:0]    phase,
  output logic             almost_full,
  output logic             accept,
  output logic             pop_valid,
  output logic [PAY_W-1:0] pop_payload
);

  logic [CD_W-1:0]  cd_q  [DEPTH];
  logic [PAY_W-1:0] pay_q [DEPTH];
  logic [CD_W-1:0]  cd_n  [DEPTH];
  logic [PAY_W-1:0] pay_n [DEPTH];
  logic [CD_W-1:0]  dec   [DEPTH];
  logic [DEPTH-1:0] rdy;
  logic [CNT_W-1:0] count_q, count_n;
  logic             hit;
  int               sel;
  int               keep;

  assign almost_full = (count_q >= CNT_W'(DEPTH));
  assign accept      = push_valid && !almost_full;

  // Countdown step and readiness, one lane per table slot.
  for (genvar g = 0; g < DEPTH; g++) begin : g_lane
    assign dec[g] = (cd_q[g] != '0) ? cd_q[g] - 1'b1 : '0;
    assign rdy[g] = (g < int'(count_q)) && (dec[g] == '0);
  end

  always_comb begin
    hit = 1'b0;
    sel = 0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (rdy[i]) begin
        hit = 1'b1;
        sel = i;
      end
    end
    // Close the gap left by the retiring slot, keeping arrival order.
    for (int i = 0; i < DEPTH; i++) begin
      if (hit && (i >= sel)) begin
        cd_n[i]  = (i + 1 < DEPTH) ? dec[(i + 1 < DEPTH) ? i + 1 : i] : '0;
        pay_n[i] = pay_q[(i + 1 < DEPTH) ? i + 1 : i];
      end else begin
        cd_n[i]  = dec[i];
        pay_n[i] = pay_q[i];
      end
    end
    keep = int'(count_q) - (hit ? 1 : 0);
    if (accept) begin
      cd_n[keep]  = CD_W'(hlr_latency(BASE, int'(phase)));
      pay_n[keep] = push_payload;
    end
    count_n = CNT_W'(keep) + CNT_W'(accept);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q     <= '0;
      pop_valid   <= 1'b0;
      pop_payload <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        cd_q[i] <= '0;
      end
    end else begin
      count_q   <= count_n;
      pop_valid <= hit;
      if (hit) begin
        pop_payload <= pay_q[sel];
      end
      for (int i = 0; i < DEPTH; i++) begin
        cd_q[i] <= cd_n[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      pay_q[i] <= pay_n[i];
    end
  end

  // R3: while the flag is up nothing new enters the table.
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    almost_full |=> (count_q <= $past(count_q)));

  // R2: occupancy never exceeds the almost-full level.
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(DEPTH));

  // R1: an empty table cannot answer on the next edge (latency >= BASE).
  assert_empty_silent_R1: assert property (@(posedge clk) disable iff (rst)
    (count_q == '0) |=> !pop_valid);

  // R10: each response strobe removes exactly one entry.
  assert_one_retire_R10: assert property (@(posedge clk) disable iff (rst)
    pop_valid |-> (int'(count_q) == int'($past(count_q)) + int'($past(accept)) - 1));

endmodule

// File: rtl/hostline_responder.sv
module hostline_responder
  import hlr_pkg::*;
#(
  parameter int unsigned LINE_W     = 512,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned TAG_W      = 12,
  parameter int unsigned AF_LEVEL   = 16,
  parameter int unsigned LAT_BASE   = 8,
  parameter int unsigned LAT_PHASES = 8,
  localparam int unsigned PW = (LAT_PHASES > 1) ? $clog2(LAT_PHASES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req_valid,
  input  logic [ADDR_W-1:0] rd_req_addr,
  input  logic [TAG_W-1:0]  rd_req_tag,
  output logic              rd_almost_full,
  input  logic              wr_req_valid,
  input  logic [ADDR_W-1:0] wr_req_addr,
  input  logic [TAG_W-1:0]  wr_req_tag,
  input  logic [LINE_W-1:0] wr_req_data,
  output logic              wr_almost_full,
  output logic              rd_rsp_valid,
  output logic [TAG_W-1:0]  rd_rsp_tag,
  output logic [LINE_W-1:0] rd_rsp_data,
  output logic              wr_rsp_valid,
  output logic [TAG_W-1:0]  wr_rsp_tag
);

  localparam int unsigned RD_PAY_W = TAG_W + LINE_W;

  logic [PW-1:0]       phase;
  logic [LINE_W-1:0]   mem_rdata;
  logic                rd_accept, wr_accept;
  logic [RD_PAY_W-1:0] rd_pop;

  hlr_phase_counter #(.PHASES(LAT_PHASES)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .phase (phase)
  );

  hlr_line_mem #(.LINE_W(LINE_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (wr_accept),
    .waddr (wr_req_addr),
    .wdata (wr_req_data),
    .raddr (rd_req_addr),
    .rdata (mem_rdata)
  );

  hlr_pending_table #(
    .PAY_W(RD_PAY_W), .DEPTH(AF_LEVEL), .BASE(LAT_BASE), .PHASES(LAT_PHASES)
  ) u_rd_tab (
    .clk          (clk),
    .rst          (rst),
    .push_valid   (rd_req_valid),
    .push_payload ({rd_req_tag, mem_rdata}),
    .phase        (phase),
    .almost_full  (rd_almost_full),
    .accept       (rd_accept),
    .pop_valid    (rd_rsp_valid),
    .pop_payload  (rd_pop)
  );

  assign rd_rsp_tag  = rd_pop[RD_PAY_W-1:LINE_W];
  assign rd_rsp_data = rd_pop[LINE_W-1:0];

  hlr_pending_table #(
    .PAY_W(TAG_W), .DEPTH(AF_LEVEL), .BASE(LAT_BASE), .PHASES(LAT_PHASES)
  ) u_wr_tab (
    .clk          (clk),
    .rst          (rst),
    .push_valid   (wr_req_valid),
    .push_payload (wr_req_tag),
    .phase        (phase),
    .almost_full  (wr_almost_full),
    .accept       (wr_accept),
    .pop_valid    (wr_rsp_valid),
    .pop_payload  (wr_rsp_tag)
  );

  // R8: acceptance on one channel never depends on the other's flag.
  assert_chan_indep_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_req_valid && !wr_almost_full) |-> wr_accept);

  logic unused_rd_accept;
  assign unused_rd_accept = rd_accept;

endmodule

// File: tb/hostline_responder_test.sv
`timescale 1ns/1ps
module hostline_responder_test;

  localparam int LINE_W = 512;
  localparam int ADDR_W = 4;
  localparam int TAG_W  = 12;
  localparam int AF     = 6;
  localparam int NLINES = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rd_req_valid = 1'b0;
  logic [ADDR_W-1:0] rd_req_addr = '0;
  logic [TAG_W-1:0]  rd_req_tag = '0;
  logic              rd_almost_full;
  logic              wr_req_valid = 1'b0;
  logic [ADDR_W-1:0] wr_req_addr = '0;
  logic [TAG_W-1:0]  wr_req_tag = '0;
  logic [LINE_W-1:0] wr_req_data = '0;
  logic              wr_almost_full;
  logic              rd_rsp_valid;
  logic [TAG_W-1:0]  rd_rsp_tag;
  logic [LINE_W-1:0] rd_rsp_data;
  logic              wr_rsp_valid;
  logic [TAG_W-1:0]  wr_rsp_tag;

  always #10 clk = ~clk;

  hostline_responder #(.LINE_W(LINE_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .AF_LEVEL(AF)) uut (
    .clk(clk), .rst(rst),
    .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr), .rd_req_tag(rd_req_tag),
    .rd_almost_full(rd_almost_full),
    .wr_req_valid(wr_req_valid), .wr_req_addr(wr_req_addr), .wr_req_tag(wr_req_tag),
    .wr_req_data(wr_req_data), .wr_almost_full(wr_almost_full),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_tag(rd_rsp_tag), .rd_rsp_data(rd_rsp_data),
    .wr_rsp_valid(wr_rsp_valid), .wr_rsp_tag(wr_rsp_tag)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req,
                     input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [LINE_W-1:0] pat(input int s);
    logic [LINE_W-1:0] r;
    for (int k = 0; k < LINE_W / 32; k++) r[k*32 +: 32] = 32'(s) * 32'h9E3779B1 + 32'(k);
    return r;
  endfunction

  // Scoreboard model: pending queues advanced by the driver-side stimulus.
  typedef struct {
    logic [TAG_W-1:0]  tag;
    logic [LINE_W-1:0] data;
    int                cd;
  } ent_t;

  ent_t              rq[$];
  ent_t              wq[$];
  logic [LINE_W-1:0] mem_m [NLINES];
  int                phase_m = 0;
  logic              e_rv = 1'b0, e_wv = 1'b0;
  ent_t              e_r, e_w;
  int acc_r = 0, acc_w = 0, blk_r = 0, n_rd = 0, n_wr = 0;
  logic [TAG_W-1:0]  seen_rd[$];
  logic [LINE_W-1:0] got [int];

  always @(posedge clk) begin
    if (rst) begin
      rq.delete(); wq.delete();
      phase_m = 0; e_rv = 1'b0; e_wv = 1'b0;
    end else begin
      bit raf, waf;
      int ix;
      raf = (rq.size() >= AF);
      waf = (wq.size() >= AF);
      foreach (rq[i]) if (rq[i].cd > 0) rq[i].cd--;
      ix = -1;
      foreach (rq[i]) if (ix < 0 && rq[i].cd == 0) ix = i;
      e_rv = (ix >= 0);
      if (ix >= 0) begin e_r = rq[ix]; rq.delete(ix); end
      foreach (wq[i]) if (wq[i].cd > 0) wq[i].cd--;
      ix = -1;
      foreach (wq[i]) if (ix < 0 && wq[i].cd == 0) ix = i;
      e_wv = (ix >= 0);
      if (ix >= 0) begin e_w = wq[ix]; wq.delete(ix); end
      if (rd_req_valid && !raf) begin
        ent_t n;
        n.tag = rd_req_tag; n.data = mem_m[rd_req_addr]; n.cd = 8 + phase_m;
        rq.push_back(n); acc_r++;
      end else if (rd_req_valid) blk_r++;
      if (wr_req_valid && !waf) begin
        ent_t n;
        n.tag = wr_req_tag; n.data = '0; n.cd = 8 + phase_m;
        wq.push_back(n); acc_w++;
        mem_m[wr_req_addr] = wr_req_data;
      end
      phase_m = (phase_m + 1) % 8;
    end
  end

  // Monitor: compares every output against the model away from the edge.
  always @(negedge clk) begin
    if (!rst) begin
      chk(rd_rsp_valid === e_rv, "R1", LINE_W'(rd_rsp_valid), LINE_W'(e_rv));
      chk(wr_rsp_valid === e_wv, "R1", LINE_W'(wr_rsp_valid), LINE_W'(e_wv));
      if (e_rv && rd_rsp_valid) begin
        chk(rd_rsp_tag === e_r.tag, "R5", LINE_W'(rd_rsp_tag), LINE_W'(e_r.tag));
        chk(rd_rsp_data === e_r.data, "R6/R7", rd_rsp_data, e_r.data);
      end
      if (e_wv && wr_rsp_valid)
        chk(wr_rsp_tag === e_w.tag, "R5", LINE_W'(wr_rsp_tag), LINE_W'(e_w.tag));
      chk(rd_almost_full === (rq.size() >= AF), "R2", LINE_W'(rd_almost_full), LINE_W'(rq.size() >= AF));
      chk(wr_almost_full === (wq.size() >= AF), "R2", LINE_W'(wr_almost_full), LINE_W'(wq.size() >= AF));
      if (rd_rsp_valid) begin
        seen_rd.push_back(rd_rsp_tag);
        got[int'(rd_rsp_tag)] = rd_rsp_data;
        n_rd++;
      end
      if (wr_rsp_valid) n_wr++;
    end
  end

  // Driver: sets inputs at a falling edge and holds them for one rising edge.
  task automatic drive(input bit rv, input int ra, input int rt,
                       input bit wv, input int wa, input int wt, input logic [LINE_W-1:0] wd);
    rd_req_valid = rv; rd_req_addr = ADDR_W'(ra); rd_req_tag = TAG_W'(rt);
    wr_req_valid = wv; wr_req_addr = ADDR_W'(wa); wr_req_tag = TAG_W'(wt); wr_req_data = wd;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, '0);
  endtask

  task automatic do_reset();
    rd_req_valid = 0; wr_req_valid = 0; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R9: outputs quiet straight after reset
    chk(rd_rsp_valid === 1'b0, "R9", LINE_W'(rd_rsp_valid), '0);
    chk(wr_rsp_valid === 1'b0, "R9", LINE_W'(wr_rsp_valid), '0);
    chk(rd_almost_full === 1'b0, "R9", LINE_W'(rd_almost_full), '0);
    chk(wr_almost_full === 1'b0, "R9", LINE_W'(wr_almost_full), '0);
  endtask

  initial begin
    int tag, d0_r, d0_w, d0_ar, d0_aw, nr0;
    @(negedge clk);
    do_reset();
    for (int a = 0; a < NLINES; a++) drive(0, 0, 0, 1, a, 900 + a, pat(a));
    idle(30);

    // R4: older slow request overtaken by a younger fast one
    while (phase_m != 7) idle(1);
    seen_rd.delete();
    drive(1, 1, 100, 0, 0, 0, '0);
    drive(1, 2, 101, 0, 0, 0, '0);
    idle(25);
    chk(seen_rd.size() == 2 && seen_rd[0] == 101 && seen_rd[1] == 100, "R4",
        LINE_W'(seen_rd.size() > 0 ? seen_rd[0] : '0), LINE_W'(101));

    // R7 then R6 on line 5
    drive(0, 0, 0, 1, 5, 300, pat(500));
    drive(1, 5, 200, 0, 0, 0, '0);
    drive(1, 5, 201, 1, 5, 301, pat(501));
    drive(0, 0, 0, 1, 5, 302, pat(502));
    idle(25);
    chk(got.exists(200) && got[200] === pat(500), "R7", got.exists(200) ? got[200] : '0, pat(500));
    chk(got.exists(201) && got[201] === pat(500), "R6", got.exists(201) ? got[201] : '0, pat(500));

    // R3 and R8: saturate reads, trickle writes
    d0_r = n_rd; d0_ar = acc_r; d0_w = n_wr; d0_aw = acc_w; nr0 = blk_r;
    for (int i = 0; i < 24; i++) drive(1, i % NLINES, 400 + i, (i % 4) == 0, i % NLINES, 500 + i, pat(600 + i));
    idle(30);
    chk((blk_r > nr0) && (n_rd - d0_r == acc_r - d0_ar), "R3",
        LINE_W'(n_rd - d0_r), LINE_W'(acc_r - d0_ar));
    chk((acc_w - d0_aw == 6) && (n_wr - d0_w == 6), "R8", LINE_W'(n_wr - d0_w), LINE_W'(6));

    // Mixed traffic on both channels
    tag = 1000;
    for (int i = 0; i < 600; i++) begin
      drive(($urandom % 3) != 0, $urandom % NLINES, tag, ($urandom % 2) == 1,
            $urandom % NLINES, tag + 1, pat(tag));
      tag += 2;
    end
    idle(40);
    chk(n_rd == acc_r, "R10", LINE_W'(n_rd), LINE_W'(acc_r));
    chk(n_wr == acc_w, "R10", LINE_W'(n_wr), LINE_W'(acc_w));

    // R9: reset with work outstanding, nothing may answer afterwards
    for (int i = 0; i < 5; i++) drive(1, i, 3000 + i, 1, i, 3100 + i, pat(i));
    d0_r = n_rd; d0_w = n_wr;
    do_reset();
    idle(30);
    chk(n_rd == d0_r && n_wr == d0_w, "R9", LINE_W'(n_rd - d0_r + n_wr - d0_w), '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule